// File: doc/BRIEF.md
# Sector write-protect access gate

This block sits between a serial host interface and a shared 8192-byte memory organised as 64 sectors of 128 bytes. For every byte request it decides, in the same cycle, whether the access may proceed (grant) or must be refused (deny). It owns two small system stores: a 64-bit write-lock map, one bit per sector, and a 64-entry area of per-sector security bytes used by the contactless side. Both are readable, and writable only while the password checker reports the unlocked state.

A select input chooses between user memory and the system area. User-memory reads always pass. User-memory writes pass when the sector's lock bit is clear, or whenever the unlocked flag is set. A granted write to the system area starts an internal write cycle. The interface is busy during that cycle and refuses every request. The new value takes effect when the cycle ends. When a security byte is rewritten, a one-cycle pulse carries the sector number to the contactless-side logic so that it can reset its access state for that sector.

Top module: `sector_wp_gate`

## Requirements
- R1: With `req_sys`=0, the sector of a request is `req_addr[12:7]`. A user-memory read is granted whenever the gate is not busy.
- R2: A user-memory write to a sector whose lock bit is 1 is denied while `unlocked`=0. It is granted if that bit is 0, or if `unlocked`=1 whatever the bit says.
- R3: With `req_sys`=1, reads are always granted (when not busy) and return data on `rd_data` in the same cycle. System address n (0..63) is the security byte of sector n. System address 2048+k (k=0..7) is lock byte k, and its bit j is the lock bit of sector 8k+j.
- R4: A system-area write is granted only while `unlocked`=1. A denied system write leaves both stores unchanged and starts no busy period.
- R5: A system-area request to any other address is denied.
- R6: After a granted system write in cycle c, the gate is busy in cycles c+1..c+WR_CYCLES (default 4) and denies every request in them. The written value is visible from cycle c+WR_CYCLES+1.
- R7: When a security-byte write completes, `rearm` is high for exactly cycle c+WR_CYCLES+1 and `rearm_sector` gives that sector. A lock-byte write raises no `rearm`.
- R8: After reset, every lock bit and every security byte is 0, and the gate is not busy.
- R9: `grant` and `deny` are combinational from the request. Exactly one of them is high in a cycle with `req_valid`=1, and neither is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| req_valid | input | 1 | A request is present this cycle |
| req_sys | input | 1 | 0: user memory, 1: system area |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data for system-area writes |
| unlocked | input | 1 | Password accepted, from the password checker |
| grant | output | 1 | Access allowed this cycle |
| deny | output | 1 | Access refused this cycle |
| rd_data | output | 8 | System-area read data; 0 when not a granted system read |
| rearm | output | 1 | One-cycle pulse: a security byte was rewritten |
| rearm_sector | output | 6 | Sector whose security byte was rewritten |

## Verification
`grant`, `deny` and `rd_data` are due in the cycle of the request itself. The bench drives each request just after a falling edge and samples these outputs 1 ns later, before the rising edge that ends the request. A system write is followed by exactly WR_CYCLES request cycles in which the bench expects deny and a low `rearm`. The read in the next cycle must then show both the new value and, for a security byte, the `rearm` pulse with its sector number. The cycle after that must show `rearm` low again.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RGN_USER = 2'd0,
    RGN_SSS  = 2'd1,
    RGN_LOCK = 2'd2,
    RGN_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode
  import wp_gate_pkg::*;
#(
  parameter int ADDR_W          = 13,
  parameter int SECT_BYTES_LOG2 = 7,
  parameter int NUM_SECTORS     = 64,
  parameter int LOCK_BASE       = 2048,
  localparam int SECT_W         = $clog2(NUM_SECTORS),
  localparam int LOCK_BYTES     = NUM_SECTORS / BYTE_W,
  localparam int LB_W           = $clog2(LOCK_BYTES)
) (
  input  logic              sys_sel,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [SECT_W-1:0] user_sector,
  output logic [SECT_W-1:0] sss_index,
  output logic [LB_W-1:0]   lock_byte
);
  localparam logic [ADDR_W-1:0] SSS_END = ADDR_W'(NUM_SECTORS);
  localparam logic [ADDR_W-1:0] LOCK_LO = ADDR_W'(LOCK_BASE);
  localparam logic [ADDR_W-1:0] LOCK_HI = ADDR_W'(LOCK_BASE + LOCK_BYTES);

  assign user_sector = addr[SECT_BYTES_LOG2 +: SECT_W];
  assign sss_index   = addr[SECT_W-1:0];
  assign lock_byte   = addr[LB_W-1:0];

  always_comb begin
    if (!sys_sel) begin
      region = RGN_USER;
    end else if (addr < SSS_END) begin
      region = RGN_SSS;
    end else if ((addr >= LOCK_LO) && (addr < LOCK_HI)) begin
      region = RGN_LOCK;
    end else begin
      region = RGN_NONE;
    end
  end
endmodule

// File: rtl/wp_lock_map.sv
module wp_lock_map
  import wp_gate_pkg::*;
#(
  parameter int NUM_SECTORS = 64,
  localparam int SECT_W     = $clog2(NUM_SECTORS),
  localparam int LOCK_BYTES = NUM_SECTORS / BYTE_W,
  localparam int LB_W       = $clog2(LOCK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LB_W-1:0]   wr_byte,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [LB_W-1:0]   rd_byte,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [SECT_W-1:0] sector,
  output logic              sector_locked
);
  logic [NUM_SECTORS-1:0] lock_bits;

  for (genvar b = 0; b < LOCK_BYTES; b++) begin : g_byte
    logic              byte_en;
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] byte_d;

    assign byte_en = wr_en && (wr_byte == LB_W'(b));

    always_comb begin
      byte_d = byte_q;
      if (byte_en) begin
        byte_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (byte_en) begin
        byte_q <= byte_d;
      end
    end

    assign lock_bits[b*BYTE_W +: BYTE_W] = byte_q;
  end

  assign rd_data       = lock_bits[rd_byte*BYTE_W +: BYTE_W];
  assign sector_locked = lock_bits[sector];
endmodule

// File: rtl/wp_sss_area.sv
module wp_sss_area
  import wp_gate_pkg::*;
#(
  parameter int NUM_SECTORS = 64,
  localparam int SECT_W     = $clog2(NUM_SECTORS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SECT_W-1:0] wr_index,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [SECT_W-1:0] rd_index,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] entry_q [NUM_SECTORS];

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_entry
    logic              ent_en;
    logic [BYTE_W-1:0] ent_d;

    assign ent_en = wr_en && (wr_index == SECT_W'(s));

    always_comb begin
      ent_d = entry_q[s];
      if (ent_en) begin
        ent_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[s] <= '0;
      end else if (ent_en) begin
        entry_q[s] <= ent_d;
      end
    end
  end

  assign rd_data = entry_q[rd_index];
endmodule

// File: rtl/wp_commit_timer.sv
module wp_commit_timer
  import wp_gate_pkg::*;
#(
  parameter int WR_CYCLES = 4,
  parameter int SECT_W    = 6,
  localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  region_e           start_region,
  input  logic [SECT_W-1:0] start_index,
  input  logic [BYTE_W-1:0] start_data,
  output logic              busy,
  output logic              fire,
  output region_e           fire_region,
  output logic [SECT_W-1:0] fire_index,
  output logic [BYTE_W-1:0] fire_data,
  output logic              rearm,
  output logic [SECT_W-1:0] rearm_index
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  region_e           rgn_q;
  logic [SECT_W-1:0] idx_q;
  logic [BYTE_W-1:0] dat_q;
  logic              rearm_q, rearm_d;
  logic [SECT_W-1:0] ridx_q;
  logic              cnt_en;

  assign busy        = (cnt_q != '0);
  assign fire        = (cnt_q == CNT_W'(1));
  assign fire_region = rgn_q;
  assign fire_index  = idx_q;
  assign fire_data   = dat_q;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = CNT_W'(WR_CYCLES);
    end else if (busy) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  assign cnt_en  = start || busy;
  assign rearm_d = fire && (rgn_q == RGN_SSS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgn_q <= RGN_NONE;
      idx_q <= '0;
      dat_q <= '0;
    end else if (start) begin
      rgn_q <= start_region;
      idx_q <= start_index;
      dat_q <= start_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rearm_q <= 1'b0;
      ridx_q  <= '0;
    end else begin
      rearm_q <= rearm_d;
      if (rearm_d) begin
        ridx_q <= idx_q;
      end
    end
  end

  assign rearm       = rearm_q;
  assign rearm_index = ridx_q;
endmodule

// File: rtl/sector_wp_gate.sv
module sector_wp_gate
  import wp_gate_pkg::*;
#(
  parameter int ADDR_W          = 13,
  parameter int SECT_BYTES_LOG2 = 7,
  parameter int NUM_SECTORS     = 64,
  parameter int LOCK_BASE       = 2048,
  parameter int WR_CYCLES       = 4,
  localparam int SECT_W         = $clog2(NUM_SECTORS),
  localparam int LB_W           = $clog2(NUM_SECTORS / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_sys,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              unlocked,
  output logic              grant,
  output logic              deny,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rearm,
  output logic [SECT_W-1:0] rearm_sector
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  region_e           region;
  logic [SECT_W-1:0] user_sector, sss_index;
  logic [LB_W-1:0]   lock_byte;
  logic              sector_locked;
  logic [BYTE_W-1:0] lock_rd, sss_rd;
  logic              busy, fire;
  region_e           fire_region;
  logic [SECT_W-1:0] fire_index;
  logic [BYTE_W-1:0] fire_data;
  logic              allow, start_wr;
  logic [SECT_W-1:0] start_index;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  wp_addr_decode #(
    .ADDR_W(ADDR_W), .SECT_BYTES_LOG2(SECT_BYTES_LOG2),
    .NUM_SECTORS(NUM_SECTORS), .LOCK_BASE(LOCK_BASE)
  ) u_decode (
    .sys_sel(req_sys), .addr(req_addr), .region(region),
    .user_sector(user_sector), .sss_index(sss_index), .lock_byte(lock_byte)
  );

  wp_lock_map #(.NUM_SECTORS(NUM_SECTORS)) u_lock (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(fire && (fire_region == RGN_LOCK)),
    .wr_byte(fire_index[LB_W-1:0]), .wr_data(fire_data),
    .rd_byte(lock_byte), .rd_data(lock_rd),
    .sector(user_sector), .sector_locked(sector_locked)
  );

  wp_sss_area #(.NUM_SECTORS(NUM_SECTORS)) u_sss (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(fire && (fire_region == RGN_SSS)),
    .wr_index(fire_index), .wr_data(fire_data),
    .rd_index(sss_index), .rd_data(sss_rd)
  );

  always_comb begin
    allow = 1'b0;
    unique case (region)
      RGN_USER: allow = !req_write || unlocked || !sector_locked;
      RGN_SSS,
      RGN_LOCK: allow = !req_write || unlocked;
      default:  allow = 1'b0;
    endcase
  end

  assign grant    = req_valid && allow && !busy;
  assign deny     = req_valid && !(allow && !busy);
  assign start_wr = grant && req_write && req_sys;

  always_comb begin
    start_index = sss_index;
    if (region == RGN_LOCK) begin
      start_index = SECT_W'(lock_byte);
    end
  end

  always_comb begin
    rd_data = '0;
    if (grant && !req_write) begin
      if (region == RGN_SSS) begin
        rd_data = sss_rd;
      end else if (region == RGN_LOCK) begin
        rd_data = lock_rd;
      end
    end
  end

  wp_commit_timer #(.WR_CYCLES(WR_CYCLES), .SECT_W(SECT_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n),
    .start(start_wr), .start_region(region), .start_index(start_index),
    .start_data(req_wdata),
    .busy(busy), .fire(fire), .fire_region(fire_region),
    .fire_index(fire_index), .fire_data(fire_data),
    .rearm(rearm), .rearm_index(rearm_sector)
  );
endmodule

// File: rtl/wp_gate_checker.sv
module wp_gate_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_sys,
  input logic req_write,
  input logic unlocked,
  input logic grant,
  input logic deny,
  input logic rearm,
  input logic busy
);
  // R9: one answer per request, none without a request
  assert_one_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (grant ^ deny));
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && !deny));
  // R1: user reads pass when idle
  assert_user_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sys && !req_write && !busy) |-> grant);
  // R2: unlocked state overrides the lock bits
  assert_override_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sys && req_write && unlocked && !busy) |-> grant);
  // R4: system writes need the unlocked state
  assert_sys_wr_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sys && req_write && !unlocked) |-> !grant);
  // R6: a granted system write opens a busy window that refuses requests
  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_sys && req_write) |=> busy);
  assert_busy_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |-> deny);
  // R7: rearm is a single pulse that ends a busy window
  assert_rearm_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !rearm);
  assert_rearm_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |-> ($past(busy) && !busy));
endmodule

bind sector_wp_gate wp_gate_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sys(req_sys),
  .req_write(req_write), .unlocked(unlocked), .grant(grant), .deny(deny),
  .rearm(rearm), .busy(busy)
);

// File: tb/sector_wp_gate_tb.sv
module sector_wp_gate_tb;
  localparam int W = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_sys, req_write, unlocked;
  logic [12:0] req_addr;
  logic [7:0]  req_wdata;
  logic        grant, deny, rearm;
  logic [7:0]  rd_data;
  logic [5:0]  rearm_sector;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic       s_g, s_d, s_r;
  logic [7:0] s_rd;
  logic [5:0] s_rs;

  always #2.5 clk = ~clk;

  sector_wp_gate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sys(req_sys),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .unlocked(unlocked), .grant(grant), .deny(deny), .rd_data(rd_data),
    .rearm(rearm), .rearm_sector(rearm_sector)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic sys, input logic wr,
                       input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = v; req_sys = sys; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    s_g = grant; s_d = deny; s_rd = rd_data; s_r = rearm; s_rs = rearm_sector;
  endtask

  task automatic busy_window(input string tag);
    for (int i = 0; i < W; i++) begin
      apply(1'b1, 1'b0, 1'b0, 13'd5, 8'h00);
      chk({s_g, s_d}, 2'b01, {tag, " busy deny"});
      chk(s_r, 1'b0, {tag, " no rearm while busy"});
    end
  endtask

  task automatic t_reset;
    apply(1'b0, 1'b0, 1'b0, 13'd0, 8'h00);
    chk({s_g, s_d, s_r}, 3'b000, "R9 idle no answer / R8 no rearm");
    for (int k = 0; k < 8; k++) begin
      apply(1'b1, 1'b1, 1'b0, 13'(2048 + k), 8'h00);
      chk({s_g, s_rd}, {1'b1, 8'h00}, "R8 lock byte zero after reset");
    end
    apply(1'b1, 1'b1, 1'b0, 13'd63, 8'h00);
    chk({s_g, s_rd}, {1'b1, 8'h00}, "R8 security byte zero after reset");
    apply(1'b1, 1'b0, 1'b1, 13'(63*128), 8'h00);
    chk(s_g, 1'b1, "R8 user write allowed after reset");
  endtask

  task automatic t_lock_program;
    unlocked = 1'b1;
    apply(1'b1, 1'b1, 1'b1, 13'd2048, 8'h06);
    chk({s_g, s_d}, 2'b10, "R4 unlocked lock write granted");
    busy_window("R6 lock byte0");
    apply(1'b1, 1'b1, 1'b1, 13'd2055, 8'h80);
    chk(s_g, 1'b1, "R4 lock byte7 write granted");
    busy_window("R6 lock byte7");
    unlocked = 1'b0;
    apply(1'b1, 1'b1, 1'b0, 13'd2048, 8'h00);
    chk({s_g, s_rd, s_r}, {1'b1, 8'h06, 1'b0}, "R3 lock byte0 readback / R7 no rearm");
    apply(1'b1, 1'b1, 1'b0, 13'd2055, 8'h00);
    chk({s_g, s_rd}, {1'b1, 8'h80}, "R3 lock byte7 readback");
    apply(1'b1, 1'b0, 1'b1, 13'(1*128 + 3), 8'h00);
    chk({s_g, s_d}, 2'b01, "R2 sector1 write denied");
    apply(1'b1, 1'b0, 1'b1, 13'(2*128 + 127), 8'h00);
    chk({s_g, s_d}, 2'b01, "R2 sector2 write denied");
    apply(1'b1, 1'b0, 1'b1, 13'(0*128 + 127), 8'h00);
    chk(s_g, 1'b1, "R2 sector0 write granted");
    apply(1'b1, 1'b0, 1'b1, 13'(3*128), 8'h00);
    chk(s_g, 1'b1, "R2 sector3 write granted");
    apply(1'b1, 1'b0, 1'b1, 13'(63*128 + 9), 8'h00);
    chk({s_g, s_d}, 2'b01, "R2 sector63 write denied");
    apply(1'b1, 1'b0, 1'b0, 13'(1*128 + 3), 8'h00);
    chk(s_g, 1'b1, "R1 read of locked sector granted");
  endtask

  task automatic t_override;
    unlocked = 1'b1;
    apply(1'b1, 1'b0, 1'b1, 13'(1*128 + 3), 8'h00);
    chk(s_g, 1'b1, "R2 unlocked overrides lock sector1");
    apply(1'b1, 1'b0, 1'b1, 13'(63*128), 8'h00);
    chk(s_g, 1'b1, "R2 unlocked overrides lock sector63");
    unlocked = 1'b0;
  endtask

  task automatic t_sys_locked;
    apply(1'b1, 1'b1, 1'b1, 13'd4, 8'h5A);
    chk({s_g, s_d}, 2'b01, "R4 security write denied while locked");
    apply(1'b1, 1'b1, 1'b0, 13'd4, 8'h00);
    chk({s_g, s_rd}, {1'b1, 8'h00}, "R4 security byte unchanged, no busy");
    apply(1'b1, 1'b1, 1'b1, 13'd2048, 8'hFF);
    chk({s_g, s_d}, 2'b01, "R4 lock write denied while locked");
    apply(1'b1, 1'b1, 1'b0, 13'd2048, 8'h00);
    chk({s_g, s_rd}, {1'b1, 8'h06}, "R4 lock byte unchanged");
  endtask

  task automatic t_unmapped;
    apply(1'b1, 1'b1, 1'b0, 13'd100, 8'h00);
    chk({s_g, s_d}, 2'b01, "R5 unmapped read 100 denied");
    apply(1'b1, 1'b1, 1'b0, 13'd2056, 8'h00);
    chk({s_g, s_d}, 2'b01, "R5 unmapped read 2056 denied");
    unlocked = 1'b1;
    apply(1'b1, 1'b1, 1'b1, 13'd64, 8'h11);
    chk({s_g, s_d}, 2'b01, "R5 unmapped write 64 denied");
    apply(1'b1, 1'b0, 1'b0, 13'd0, 8'h00);
    chk(s_g, 1'b1, "R5 denied write started no busy");
    unlocked = 1'b0;
  endtask

  task automatic t_rearm;
    unlocked = 1'b1;
    apply(1'b1, 1'b1, 1'b1, 13'd9, 8'h0B);
    chk(s_g, 1'b1, "R4 security byte9 write granted");
    busy_window("R6 security byte9");
    apply(1'b1, 1'b1, 1'b0, 13'd9, 8'h00);
    chk({s_r, s_rs}, {1'b1, 6'd9}, "R7 rearm pulse with sector 9");
    chk({s_g, s_rd}, {1'b1, 8'h0B}, "R6 new value visible after window");
    apply(1'b0, 1'b0, 1'b0, 13'd0, 8'h00);
    chk(s_r, 1'b0, "R7 rearm lasts one cycle");
    unlocked = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_sys = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; unlocked = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lock_program();
    t_override();
    t_sys_locked();
    t_unmapped();
    t_rearm();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule